// File: doc/BRIEF.md
# Rename Stage Stall and Squash Controller

This block is the control half of a register-rename pipeline stage in an out-of-order core. It decides what each hardware thread does every cycle. A thread may rename a group of instructions, block, drain its skid buffer after a block, discard work during a squash, or hold on a serializing (barrier) instruction. Operand lookup and the map table live elsewhere. This block only produces the per-thread rename count and the handshakes around it.

Each cycle a thread offers the controller several inputs:
- how many decoded instructions are ready (or, while unblocking, how many wait in its skid buffer);
- the free entries of the reorder buffer, issue queue and load/store queue, plus the count of instructions already sent toward them but not yet counted;
- the free physical registers;
- stall requests from execute and commit;
- squash control;
- the reorder-buffer-empty flag.

All per-thread decisions are registered, so every result appears one clock edge after the inputs that caused it. A combinational stage-activity flag tells the rest of the core when rename has nothing to do.

Top module: `rn_stage_ctl`

## Requirements
- R1: After reset every thread is in the idle state, with rename count, strobes and all event counters at zero. The state codes on `thr_state` are idle=0, running=1, squash-start=2, squashing=3, blocked=4, unblocking=5 and barrier-wait=6.
- R2: In the running or idle state without a stall or shortage, the rename count is the minimum of four values: the width `W`, the instructions offered, each queue's free count less the in-flight count (floored at zero), and the free registers. The state becomes running when instructions were offered and idle otherwise.
- R3: A stall from execute or commit in the running or idle state moves the thread to blocked with zero renamed. A structure too small for the offered group does the same but renames the part that fits. Either way `block_o` pulses, and `skid_ins_o` pulses when some offered instructions were left unrenamed.
- R4: Blocked moves to unblocking once both external stalls are low. Unblocking renames from the skid-buffer count. The thread returns to running, with an `unblock_o` pulse, only when that count is zero.
- R5: An offered group whose head is a barrier sends the thread to barrier-wait with zero renamed. The thread stays there until the reorder buffer is empty and nothing is in flight. It then returns to running with a one-cycle `barrier_go` pulse.
- R6: A serialize-after request marks the next offered group as a barrier, and the mark is consumed when barrier-wait is entered.
- R7: On a block caused by a structure shortage, exactly one queue counter increments, chosen in priority order: reorder buffer first, then issue queue, then load/store queue.
- R8: A block in which the free registers are fewer than the offered instructions increments the register-shortage counter.
- R9: A squash request overrides every other condition. The thread spends one cycle in squash-start, then stays in squashing until `squash_done`, then goes idle.
- R10: `stage_active` is low only when every thread is idle or blocked and every skid-buffer count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| avail | input | NT*AW | Instructions offered per thread |
| head_barrier | input | NT | Head of offered group is a barrier |
| ser_after | input | NT | Serialize-after request |
| free_rob | input | NT*FW | Free reorder-buffer entries |
| free_iq | input | NT*FW | Free issue-queue entries |
| free_lsq | input | NT*FW | Free load/store-queue entries |
| free_regs | input | NT*FW | Free physical registers |
| in_flight | input | NT*FW | Sent but not yet counted instructions |
| stall_exec | input | NT | Stall from execute |
| stall_commit | input | NT | Stall from commit |
| squash_req | input | NT | Squash request |
| squash_done | input | NT | Rollback finished |
| rob_empty | input | NT | Reorder buffer empty |
| skid_cnt | input | NT*SW | Skid-buffer occupancy |
| ren_cnt | output | NT*AW | Instructions renamed |
| block_o | output | NT | Block pulse toward decode |
| unblock_o | output | NT | Unblock pulse toward decode |
| skid_ins_o | output | NT | Insert leftovers into skid buffer |
| barrier_go | output | NT | Barrier released |
| thr_state | output | NT*3 | Thread state code |
| ev_rob | output | NT*EW | Reorder-buffer shortage events |
| ev_iq | output | NT*EW | Issue-queue shortage events |
| ev_lsq | output | NT*EW | Load/store-queue shortage events |
| ev_reg | output | NT*EW | Register shortage events |
| stage_active | output | 1 | Stage has work |

## Verification
State, rename count, block, unblock, skid-insert and barrier-release results, and the event counters, are due at the first rising edge after the inputs are applied. The driver applies inputs on a falling edge and queues the expected values. The monitor compares them shortly after the next rising edge, so each comparison sees exactly one decision. `stage_active` is combinational from the registered states and the current skid counts, so it is checked one nanosecond after a skid count changes, or after the rising edge that moved a state.

// File: rtl/rn_pkg.sv
package rn_pkg;
   typedef enum logic [2:0] {
      RN_IDLE     = 3'd0,
      RN_RUN      = 3'd1,
      RN_SQ_START = 3'd2,
      RN_SQ_BUSY  = 3'd3,
      RN_BLOCKED  = 3'd4,
      RN_UNBLOCK  = 3'd5,
      RN_BARRIER  = 3'd6
   } rn_state_e;
endpackage

// File: rtl/rn_grant_calc.sv
module rn_grant_calc #(
   parameter int W  = 4,
   parameter int AW = 3,
   parameter int FW = 6
) (
   input  logic [AW-1:0] src,
   input  logic [FW-1:0] free_rob,
   input  logic [FW-1:0] free_iq,
   input  logic [FW-1:0] free_lsq,
   input  logic [FW-1:0] free_regs,
   input  logic [FW-1:0] in_flight,
   output logic [AW-1:0] grant,
   output logic          short_rob,
   output logic          short_iq,
   output logic          short_lsq,
   output logic          short_reg
);
   function automatic logic [FW-1:0] room(input logic [FW-1:0] f, input logic [FW-1:0] u);
      return (f > u) ? (f - u) : '0;
   endfunction

   logic [FW-1:0] a_rob, a_iq, a_lsq, srcw, m;

   always_comb begin
      a_rob = room(free_rob, in_flight);
      a_iq  = room(free_iq, in_flight);
      a_lsq = room(free_lsq, in_flight);
      srcw  = FW'(src);
      m     = FW'(W);
      if (srcw < m)      m = srcw;
      if (a_rob < m)     m = a_rob;
      if (a_iq < m)      m = a_iq;
      if (a_lsq < m)     m = a_lsq;
      if (free_regs < m) m = free_regs;
      grant     = AW'(m);
      short_rob = a_rob < srcw;
      short_iq  = a_iq < srcw;
      short_lsq = a_lsq < srcw;
      short_reg = free_regs < srcw;
   end
endmodule

// File: rtl/rn_event_ctr.sv
module rn_event_ctr #(
   parameter int EW       = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [EW-1:0] cnt
);
   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)                  cnt <= '0;
            else if (inc && cnt != '1)   cnt <= cnt + 1'b1;
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rn_thread_ctl.sv
module rn_thread_ctl
   import rn_pkg::*;
#(
   parameter int W        = 4,
   parameter int AW       = 3,
   parameter int FW       = 6,
   parameter int SW       = 4,
   parameter int EW       = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] avail,
   input  logic          head_barrier,
   input  logic          ser_after,
   input  logic [FW-1:0] free_rob,
   input  logic [FW-1:0] free_iq,
   input  logic [FW-1:0] free_lsq,
   input  logic [FW-1:0] free_regs,
   input  logic [FW-1:0] in_flight,
   input  logic          stall_exec,
   input  logic          stall_commit,
   input  logic          squash_req,
   input  logic          squash_done,
   input  logic          rob_empty,
   input  logic [SW-1:0] skid_cnt,
   output logic [2:0]    state_o,
   output logic [AW-1:0] ren_o,
   output logic          block_o,
   output logic          unblock_o,
   output logic          skid_ins_o,
   output logic          bar_go_o,
   output logic [EW-1:0] ev_rob_o,
   output logic [EW-1:0] ev_iq_o,
   output logic [EW-1:0] ev_lsq_o,
   output logic [EW-1:0] ev_reg_o
);
   rn_state_e st, nst;
   logic      pend, pend_n;
   logic [AW-1:0] skid_cl, src, grant, ren_n;
   logic sr, si, sl, sg, ext, short_any;
   logic blk_n, ub_n, ski_n, go_n;
   logic inc_r, inc_i, inc_l, inc_g;

   assign skid_cl   = (skid_cnt > SW'(W)) ? AW'(W) : AW'(skid_cnt);
   assign src       = (st == RN_UNBLOCK) ? skid_cl : avail;
   assign ext       = stall_exec | stall_commit;
   assign short_any = sr | si | sl | sg;

   rn_grant_calc #(.W(W), .AW(AW), .FW(FW)) u_calc (
      .src(src), .free_rob(free_rob), .free_iq(free_iq), .free_lsq(free_lsq),
      .free_regs(free_regs), .in_flight(in_flight), .grant(grant),
      .short_rob(sr), .short_iq(si), .short_lsq(sl), .short_reg(sg));

   always_comb begin
      nst    = st;
      ren_n  = '0;
      blk_n  = 1'b0;
      ub_n   = 1'b0;
      ski_n  = 1'b0;
      go_n   = 1'b0;
      pend_n = pend | ser_after;
      if (squash_req) begin
         nst    = RN_SQ_START;
         pend_n = 1'b0;
      end else begin
         case (st)
            RN_SQ_START: nst = RN_SQ_BUSY;
            RN_SQ_BUSY:  if (squash_done) nst = RN_IDLE;
            RN_BARRIER:
               if (rob_empty && in_flight == '0) begin
                  nst  = RN_RUN;
                  go_n = 1'b1;
               end
            RN_BLOCKED:  if (!ext) nst = RN_UNBLOCK;
            RN_UNBLOCK:
               if (ext || short_any) begin
                  nst   = RN_BLOCKED;
                  blk_n = 1'b1;
                  ren_n = ext ? '0 : grant;
               end else begin
                  ren_n = grant;
                  if (skid_cnt == '0) begin
                     nst  = RN_RUN;
                     ub_n = 1'b1;
                  end
               end
            default:
               if (src != '0 && (head_barrier || pend)) begin
                  nst    = RN_BARRIER;
                  pend_n = ser_after;
               end else if (ext || short_any) begin
                  nst   = RN_BLOCKED;
                  blk_n = 1'b1;
                  ren_n = ext ? '0 : grant;
                  ski_n = (src != ren_n);
               end else begin
                  ren_n = grant;
                  nst   = (src != '0) ? RN_RUN : RN_IDLE;
               end
         endcase
      end
   end

   // Shortage events: one queue source in fixed priority, register shortage on its own.
   always_comb begin
      inc_r = blk_n && !ext && sr;
      inc_i = blk_n && !ext && !sr && si;
      inc_l = blk_n && !ext && !sr && !si && sl;
      inc_g = blk_n && !ext && sg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= RN_IDLE;
         pend       <= 1'b0;
         ren_o      <= '0;
         block_o    <= 1'b0;
         unblock_o  <= 1'b0;
         skid_ins_o <= 1'b0;
         bar_go_o   <= 1'b0;
      end else begin
         st         <= nst;
         pend       <= pend_n;
         ren_o      <= ren_n;
         block_o    <= blk_n;
         unblock_o  <= ub_n;
         skid_ins_o <= ski_n;
         bar_go_o   <= go_n;
      end
   end

   assign state_o = st;

   rn_event_ctr #(.EW(EW), .SATURATE(SATURATE)) u_ev_rob (.clk(clk), .rst_n(rst_n), .inc(inc_r), .cnt(ev_rob_o));
   rn_event_ctr #(.EW(EW), .SATURATE(SATURATE)) u_ev_iq  (.clk(clk), .rst_n(rst_n), .inc(inc_i), .cnt(ev_iq_o));
   rn_event_ctr #(.EW(EW), .SATURATE(SATURATE)) u_ev_lsq (.clk(clk), .rst_n(rst_n), .inc(inc_l), .cnt(ev_lsq_o));
   rn_event_ctr #(.EW(EW), .SATURATE(SATURATE)) u_ev_reg (.clk(clk), .rst_n(rst_n), .inc(inc_g), .cnt(ev_reg_o));
endmodule

// File: rtl/rn_stage_ctl.sv
module rn_stage_ctl
   import rn_pkg::*;
#(
   parameter int NT       = 2,
   parameter int W        = 4,
   parameter int FW       = 6,
   parameter int SW       = 4,
   parameter int EW       = 8,
   parameter bit SATURATE = 1'b1,
   localparam int AW      = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NT*AW-1:0] avail,
   input  logic [NT-1:0]    head_barrier,
   input  logic [NT-1:0]    ser_after,
   input  logic [NT*FW-1:0] free_rob,
   input  logic [NT*FW-1:0] free_iq,
   input  logic [NT*FW-1:0] free_lsq,
   input  logic [NT*FW-1:0] free_regs,
   input  logic [NT*FW-1:0] in_flight,
   input  logic [NT-1:0]    stall_exec,
   input  logic [NT-1:0]    stall_commit,
   input  logic [NT-1:0]    squash_req,
   input  logic [NT-1:0]    squash_done,
   input  logic [NT-1:0]    rob_empty,
   input  logic [NT*SW-1:0] skid_cnt,
   output logic [NT*AW-1:0] ren_cnt,
   output logic [NT-1:0]    block_o,
   output logic [NT-1:0]    unblock_o,
   output logic [NT-1:0]    skid_ins_o,
   output logic [NT-1:0]    barrier_go,
   output logic [NT*3-1:0]  thr_state,
   output logic [NT*EW-1:0] ev_rob,
   output logic [NT*EW-1:0] ev_iq,
   output logic [NT*EW-1:0] ev_lsq,
   output logic [NT*EW-1:0] ev_reg,
   output logic             stage_active
);
   initial begin
      if (NT < 1 || W < 1)       $fatal(1, "rn_stage_ctl: NT and W must be positive");
      if (FW <= AW || SW < AW)   $fatal(1, "rn_stage_ctl: count widths too narrow for W");
      if (EW < 1)                $fatal(1, "rn_stage_ctl: EW must be positive");
   end

   for (genvar t = 0; t < NT; t++) begin : g_thr
      rn_thread_ctl #(.W(W), .AW(AW), .FW(FW), .SW(SW), .EW(EW), .SATURATE(SATURATE)) u_thr (
         .clk(clk), .rst_n(rst_n),
         .avail(avail[t*AW +: AW]),
         .head_barrier(head_barrier[t]), .ser_after(ser_after[t]),
         .free_rob(free_rob[t*FW +: FW]), .free_iq(free_iq[t*FW +: FW]),
         .free_lsq(free_lsq[t*FW +: FW]), .free_regs(free_regs[t*FW +: FW]),
         .in_flight(in_flight[t*FW +: FW]),
         .stall_exec(stall_exec[t]), .stall_commit(stall_commit[t]),
         .squash_req(squash_req[t]), .squash_done(squash_done[t]),
         .rob_empty(rob_empty[t]), .skid_cnt(skid_cnt[t*SW +: SW]),
         .state_o(thr_state[t*3 +: 3]), .ren_o(ren_cnt[t*AW +: AW]),
         .block_o(block_o[t]), .unblock_o(unblock_o[t]),
         .skid_ins_o(skid_ins_o[t]), .bar_go_o(barrier_go[t]),
         .ev_rob_o(ev_rob[t*EW +: EW]), .ev_iq_o(ev_iq[t*EW +: EW]),
         .ev_lsq_o(ev_lsq[t*EW +: EW]), .ev_reg_o(ev_reg[t*EW +: EW]));
   end

   logic quiet;
   always_comb begin
      quiet = 1'b1;
      for (int t = 0; t < NT; t++) begin
         if (!(thr_state[t*3 +: 3] == RN_IDLE || thr_state[t*3 +: 3] == RN_BLOCKED)) quiet = 1'b0;
         if (skid_cnt[t*SW +: SW] != '0) quiet = 1'b0;
      end
   end
   assign stage_active = !quiet;
endmodule

// File: rtl/rn_stage_ctl_chk.sv
module rn_stage_ctl_chk #(
   parameter int NT = 2,
   parameter int AW = 3,
   parameter int EW = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NT-1:0]    squash_req,
   input logic [NT-1:0]    rob_empty,
   input logic [NT*3-1:0]  thr_state,
   input logic [NT*AW-1:0] ren_cnt,
   input logic [NT-1:0]    block_o,
   input logic [NT-1:0]    unblock_o,
   input logic [NT*EW-1:0] ev_rob,
   input logic [NT*EW-1:0] ev_iq,
   input logic [NT*EW-1:0] ev_lsq
);
   for (genvar t = 0; t < NT; t++) begin : g_chk
      wire [2:0] st = thr_state[t*3 +: 3];

      p_squash_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
         squash_req[t] |=> st == 3'd2);
      p_squash_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (st == 3'd2 && !squash_req[t]) |=> st == 3'd3);
      p_unblock_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
         unblock_o[t] |-> (st == 3'd1 && $past(st) == 3'd5));
      p_block_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
         block_o[t] |-> st == 3'd4);
      p_barrier_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (st == 3'd6 && !squash_req[t] && !rob_empty[t]) |=> (st == 3'd6 && ren_cnt[t*AW +: AW] == '0));
      p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $countones({ev_rob[t*EW +: EW] != $past(ev_rob[t*EW +: EW]),
                     ev_iq[t*EW +: EW]  != $past(ev_iq[t*EW +: EW]),
                     ev_lsq[t*EW +: EW] != $past(ev_lsq[t*EW +: EW])}) <= 1);
   end
endmodule

bind rn_stage_ctl rn_stage_ctl_chk #(.NT(NT), .AW(AW), .EW(EW)) u_chk (
   .clk(clk), .rst_n(rst_n), .squash_req(squash_req), .rob_empty(rob_empty),
   .thr_state(thr_state), .ren_cnt(ren_cnt), .block_o(block_o),
   .unblock_o(unblock_o), .ev_rob(ev_rob), .ev_iq(ev_iq), .ev_lsq(ev_lsq));

// File: tb/rn_stage_ctl_test.sv
`timescale 1ns/1ps
module rn_stage_ctl_test;
   localparam int NT = 2, W = 4, AW = 3, FW = 6, SW = 4, EW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NT*AW-1:0] avail;
   logic [NT-1:0]    head_barrier, ser_after, stall_exec, stall_commit, squash_req, squash_done, rob_empty;
   logic [NT*FW-1:0] free_rob, free_iq, free_lsq, free_regs, in_flight;
   logic [NT*SW-1:0] skid_cnt;
   logic [NT*AW-1:0] ren_cnt;
   logic [NT-1:0]    block_o, unblock_o, skid_ins_o, barrier_go;
   logic [NT*3-1:0]  thr_state;
   logic [NT*EW-1:0] ev_rob, ev_iq, ev_lsq, ev_reg;
   logic             stage_active;

   rn_stage_ctl #(.NT(NT), .W(W), .FW(FW), .SW(SW), .EW(EW)) uut (.*);

   int checks = 0, failures = 0;

   // thread 0 stimulus values, thread 1 controls
   int a0, frob, fiq, flsq, freg, infl, sk;
   bit sx, sc, sq, sd, re, hb, sa, t1_sx;
   int t1_sk;
   int e_r = 0, e_i = 0, e_l = 0, e_g = 0;

   typedef struct {
      int st, ren, blk, ub, ski, go, er, ei, el, eg;
      string req;
   } exp_t;
   exp_t exq[$];

   task automatic dflt();
      a0 = 0; frob = 20; fiq = 20; flsq = 20; freg = 20; infl = 0; sk = 0;
      sx = 0; sc = 0; sq = 0; sd = 0; re = 1; hb = 0; sa = 0;
   endtask

   task automatic drive();
      avail        = {3'd0, AW'(a0)};
      free_rob     = {6'd20, FW'(frob)};
      free_iq      = {6'd20, FW'(fiq)};
      free_lsq     = {6'd20, FW'(flsq)};
      free_regs    = {6'd20, FW'(freg)};
      in_flight    = {6'd0, FW'(infl)};
      stall_exec   = {t1_sx, sx};
      stall_commit = {1'b0, sc};
      squash_req   = {1'b0, sq};
      squash_done  = {1'b0, sd};
      rob_empty    = {1'b1, re};
      head_barrier = {1'b0, hb};
      ser_after    = {1'b0, sa};
      skid_cnt     = {SW'(t1_sk), SW'(sk)};
   endtask

   task automatic step(int st, int ren, int blk, int ub, int ski, int go, string req);
      exp_t e;
      @(negedge clk);
      drive();
      e.st = st; e.ren = ren; e.blk = blk; e.ub = ub; e.ski = ski; e.go = go;
      e.er = e_r; e.ei = e_i; e.el = e_l; e.eg = e_g; e.req = req;
      exq.push_back(e);
   endtask

   task automatic chk(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: results are due one rising edge after the driver applies inputs.
   always @(posedge clk) begin
      #2;
      if (exq.size() > 0) begin
         exp_t e;
         int ast, aren, abl, aub, aski, ago, aer, aei, ael, aeg;
         e    = exq.pop_front();
         ast  = int'(thr_state[2:0]); aren = int'(ren_cnt[AW-1:0]);
         abl  = int'(block_o[0]); aub = int'(unblock_o[0]);
         aski = int'(skid_ins_o[0]); ago = int'(barrier_go[0]);
         aer  = int'(ev_rob[EW-1:0]); aei = int'(ev_iq[EW-1:0]);
         ael  = int'(ev_lsq[EW-1:0]); aeg = int'(ev_reg[EW-1:0]);
         checks++;
         if (ast != e.st || aren != e.ren || abl != e.blk || aub != e.ub || aski != e.ski ||
             ago != e.go || aer != e.er || aei != e.ei || ael != e.el || aeg != e.eg) begin
            failures++;
            $display("FAIL %s actual st=%0d ren=%0d blk=%0d ub=%0d ski=%0d go=%0d ev=%0d/%0d/%0d/%0d expected st=%0d ren=%0d blk=%0d ub=%0d ski=%0d go=%0d ev=%0d/%0d/%0d/%0d",
                     e.req, ast, aren, abl, aub, aski, ago, aer, aei, ael, aeg,
                     e.st, e.ren, e.blk, e.ub, e.ski, e.go, e.er, e.ei, e.el, e.eg);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic release_blk();
      dflt(); step(5, 0, 0, 0, 0, 0, "R4 blocked to unblocking");
      dflt(); step(1, 0, 0, 1, 0, 0, "R4 drained to running");
   endtask

   initial begin
      t1_sx = 0; t1_sk = 0;
      dflt(); drive();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(thr_state == '0 && ren_cnt == '0, "R1 state/count", int'(thr_state), 0);
      chk(block_o == '0 && unblock_o == '0 && skid_ins_o == '0 && barrier_go == '0, "R1 strobes", 0, 0);
      chk(ev_rob == '0 && ev_iq == '0 && ev_lsq == '0 && ev_reg == '0, "R1 counters", 0, 0);
      chk(stage_active == 1'b0, "R10 idle after reset", int'(stage_active), 0);

      // R2 rename count
      dflt(); a0 = 3; step(1, 3, 0, 0, 0, 0, "R2 three offered");
      dflt(); a0 = 4; infl = 2; fiq = 6; step(1, 4, 0, 0, 0, 0, "R2 in-flight adjusted fits");
      dflt(); a0 = 2; step(1, 2, 0, 0, 0, 0, "R2 two offered");
      dflt(); step(0, 0, 0, 0, 0, 0, "R2 idle when none offered");

      // R7 all short -> reorder buffer wins; R3 partial rename
      dflt(); a0 = 4; frob = 2; fiq = 1; flsq = 3; e_r++;
      step(4, 1, 1, 0, 1, 0, "R7 rob priority");
      dflt(); sx = 1; sk = 3; step(4, 0, 0, 0, 0, 0, "R3 held blocked by stall");
      dflt(); sk = 3; step(5, 0, 0, 0, 0, 0, "R4 enter unblocking");
      dflt(); sk = 3; step(5, 3, 0, 0, 0, 0, "R4 rename from skid");
      dflt(); step(1, 0, 0, 1, 0, 0, "R4 unblock when skid empty");

      dflt(); a0 = 4; fiq = 2; flsq = 1; e_i++;
      step(4, 1, 1, 0, 1, 0, "R7 iq over lsq");
      release_blk();
      dflt(); a0 = 4; flsq = 3; e_l++;
      step(4, 3, 1, 0, 1, 0, "R7 lsq only");
      release_blk();
      dflt(); a0 = 4; freg = 0; e_g++;
      step(4, 0, 1, 0, 1, 0, "R8 register shortage");
      release_blk();
      dflt(); a0 = 2; sc = 1; step(4, 0, 1, 0, 1, 0, "R3 commit stall");
      dflt(); sc = 1; step(4, 0, 0, 0, 0, 0, "R3 stall held");
      release_blk();
      dflt(); a0 = 4; infl = 3; frob = 6; e_r++;
      step(4, 3, 1, 0, 1, 0, "R2 in-flight shortage");
      release_blk();

      // R5 barrier
      dflt(); a0 = 2; hb = 1; re = 0; step(6, 0, 0, 0, 0, 0, "R5 barrier entry");
      dflt(); hb = 1; infl = 1; step(6, 0, 0, 0, 0, 0, "R5 wait in-flight");
      dflt(); hb = 1; step(1, 0, 0, 0, 0, 1, "R5 release");
      dflt(); a0 = 2; step(1, 2, 0, 0, 0, 0, "R5 rename after release");

      // R6 serialize-after
      dflt(); a0 = 2; sa = 1; step(1, 2, 0, 0, 0, 0, "R6 request with group");
      dflt(); step(0, 0, 0, 0, 0, 0, "R6 idle gap");
      dflt(); a0 = 1; step(6, 0, 0, 0, 0, 0, "R6 next group is barrier");
      dflt(); step(1, 0, 0, 0, 0, 1, "R6 release");
      dflt(); a0 = 1; step(1, 1, 0, 0, 0, 0, "R6 mark consumed");

      // R9 squash
      dflt(); a0 = 3; sq = 1; sx = 1; step(2, 0, 0, 0, 0, 0, "R9 squash overrides");
      dflt(); step(3, 0, 0, 0, 0, 0, "R9 squashing");
      dflt(); step(3, 0, 0, 0, 0, 0, "R9 wait done");
      dflt(); sd = 1; step(0, 0, 0, 0, 0, 0, "R9 done to idle");
      dflt();
      repeat (3) @(negedge clk);
      drive();

      // R10 stage activity
      chk(stage_active == 1'b0, "R10 all idle", int'(stage_active), 0);
      sk = 2; drive(); #1;
      chk(stage_active == 1'b1, "R10 skid occupied", int'(stage_active), 1);
      @(negedge clk);
      sk = 0; t1_sx = 1; drive();
      @(negedge clk);
      chk(thr_state[5:3] == 3'd4, "R3 thread1 blocked", int'(thr_state[5:3]), 4);
      chk(stage_active == 1'b0, "R10 idle and blocked", int'(stage_active), 0);
      t1_sk = 1; drive(); #1;
      chk(stage_active == 1'b1, "R10 blocked with skid", int'(stage_active), 1);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule